// File: doc/BRIEF.md
# Serial Receive FIFO Status Controller

This block sits on the receive side of an asynchronous serial port, between the bit-level receiver and a register bus. It takes each completed byte from the receiver shift stage and stores it in a 16-entry FIFO. It keeps a data-full flag that rises when the FIFO holds at least a programmable trigger count of bytes. When that flag goes from 0 to 1, it pulses a receive interrupt. It also keeps an overrun error flag and exposes the current FIFO occupancy.

Software works through strobes. A status-read strobe tells the block that the flags were observed. A status write carries one bit per flag, and writing 0 clears a flag only if software has read that flag as 1 beforehand. A data read pops the oldest byte. A DMA read strobe pops a byte and clears the full flag without any software write.

A small acceptance state machine controls when bytes are taken in. It has three states:
- `ST_IDLE`: reception is disabled.
- `ST_RUN`: bytes are accepted.
- `ST_HALT`: an overrun is pending.

Its transitions are:
- `ST_IDLE -> ST_RUN` when enable is high.
- `ST_RUN -> ST_IDLE` when enable drops.
- `ST_RUN -> ST_HALT` when a byte arrives at a full FIFO.
- `ST_HALT -> ST_RUN` or `ST_HALT -> ST_IDLE` once the overrun flag is 0. The target depends on enable.

Top module: `rx_fifo_status_ctrl`

## Requirements
- R1: After reset, the FIFO is empty and `rx_count` is 0. `full_flag`, `ovr_flag`, `rx_irq` and `rd_data` are all 0. The trigger code is 0, meaning a level of 1 byte.
- R2: Bytes leave in arrival order and the FIFO holds 16 of them. A `data_rd` or `dma_rd` pop loads the oldest byte onto `rd_data`, visible from the next cycle. `rx_count` gives the occupancy, zero-extended to 8 bits.
- R3: `cfg_trig_we` loads `cfg_trig_code`, with codes 0, 1, 2 and 3 meaning levels of 1, 4, 8 and 14 bytes. `full_flag` sets when a byte is stored and the count after that cycle is at or above the level.
- R4: A status-read strobe while `full_flag` is 1 arms the clear. A later `stat_wr` with `stat_wr_full`=0 then clears the flag. Any status write disarms the clear. A write of 0 without an armed read leaves the flag at 1, and a write of 1 never changes it.
- R5: `rx_irq` is high for exactly the one cycle in which `full_flag` first reads 1 after being 0.
- R6: A `dma_rd` strobe clears `full_flag` without any status write, and it pops one byte if the FIFO is not empty.
- R7: A byte that arrives while the count is 16 is discarded and sets `ovr_flag`, and the stored bytes are kept. This holds even when a pop happens in the same cycle.
- R8: `ovr_flag` clears by the same armed read-then-write-0 rule, using `stat_wr_ovr`. While it is 1, and in the cycle right after it clears, no byte is accepted.
- R9: A pop request on an empty FIFO leaves `rd_data` and `rx_count` unchanged.
- R10: While `rx_enable` is 0, no byte is accepted. After `rx_enable` rises, bytes are accepted from the following cycle on.
- R11: After `full_flag` is cleared with the count still at or above the level, the flag sets again, with an `rx_irq` pulse, on the next byte stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_enable | input | 1 | Receive enable control bit |
| byte_valid | input | 1 | Receiver shift stage delivers a byte this cycle |
| byte_data | input | 8 | Received byte |
| cfg_trig_we | input | 1 | Load trigger code |
| cfg_trig_code | input | 2 | Trigger code (0:1, 1:4, 2:8, 3:14 bytes) |
| stat_rd | input | 1 | Software reads the status flags this cycle |
| stat_wr | input | 1 | Software writes the status flags this cycle |
| stat_wr_full | input | 1 | Written value for the full flag |
| stat_wr_ovr | input | 1 | Written value for the overrun flag |
| data_rd | input | 1 | Software read of the data register (pop) |
| dma_rd | input | 1 | DMA read of the data register (pop and clear full flag) |
| rd_data | output | 8 | Last byte read from the FIFO |
| rx_count | output | 8 | Number of bytes held in the FIFO |
| full_flag | output | 1 | Receive data full flag |
| ovr_flag | output | 1 | Overrun error flag |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The assertions assume that reset is applied before the first checked edge. They also assume that `stat_rd` and `stat_wr` never occur in the same cycle, since the arming rule is only defined for a read followed by a later write. The stimulus drives every software strobe as a single-cycle pulse, one at a time. It only combines a pop with an incoming byte in the deliberate full-FIFO overrun case. Bytes are sent only after enable has had its one cycle to take effect, except where R10 is being exercised.

// File: rtl/rx_fifo_pkg.sv
package rx_fifo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } rx_state_t;

    typedef enum logic [1:0] {
        TRIG_1  = 2'd0,
        TRIG_4  = 2'd1,
        TRIG_8  = 2'd2,
        TRIG_14 = 2'd3
    } trig_code_t;

    function automatic int unsigned trig_level(input logic [1:0] code);
        int unsigned lvl;
        unique case (code)
            TRIG_1:  lvl = 1;
            TRIG_4:  lvl = 4;
            TRIG_8:  lvl = 8;
            default: lvl = 14;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/rx_byte_store.sv
module rx_byte_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic [CNT_W-1:0]  count_o
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  count_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_i) begin
            mem[wr_ptr] <= push_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (push_i) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop_i) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({push_i, pop_i})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    assign head_o  = mem[rd_ptr];
    assign count_o = count_q;

endmodule

// File: rtl/rx_sticky_flag.sv
module rx_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic sw_rd_i,
    input  logic sw_wr_i,
    input  logic sw_wbit_i,
    input  logic hw_clr_i,
    output logic flag_o
);

    logic flag_q;
    logic armed_q;
    logic clr;
    logic flag_d;
    logic armed_d;

    always_comb begin
        clr = hw_clr_i || (sw_wr_i && !sw_wbit_i && armed_q);
        if (set_i) begin
            flag_d = 1'b1;
        end else if (clr) begin
            flag_d = 1'b0;
        end else begin
            flag_d = flag_q;
        end
        if (hw_clr_i || sw_wr_i) begin
            armed_d = 1'b0;
        end else if (sw_rd_i && flag_q) begin
            armed_d = 1'b1;
        end else begin
            armed_d = armed_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            flag_q  <= flag_d;
            armed_q <= armed_d;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/rx_accept_fsm.sv
module rx_accept_fsm
    import rx_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic byte_valid_i,
    input  logic fifo_full_i,
    input  logic ovr_flag_i,
    output logic accept_o,
    output logic overrun_o
);

    rx_state_t state_q;
    rx_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (enable_i) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!enable_i) begin
                    state_d = ST_IDLE;
                end else if (byte_valid_i && fifo_full_i) begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: begin
                if (!ovr_flag_i) state_d = enable_i ? ST_RUN : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept_o  = 1'b0;
        overrun_o = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                accept_o  = enable_i && byte_valid_i && !fifo_full_i;
                overrun_o = enable_i && byte_valid_i && fifo_full_i;
            end
            default: begin
                accept_o  = 1'b0;
                overrun_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rx_fifo_status_ctrl.sv
module rx_fifo_status_ctrl
    import rx_fifo_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DATA_W    = 8,
    parameter int CNT_OUT_W = 8,
    localparam int CNT_W    = $clog2(DEPTH) + 1,
    localparam int LVL_W    = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              byte_valid,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              cfg_trig_we,
    input  logic [1:0]        cfg_trig_code,
    input  logic              stat_rd,
    input  logic              stat_wr,
    input  logic              stat_wr_full,
    input  logic              stat_wr_ovr,
    input  logic              data_rd,
    input  logic              dma_rd,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_OUT_W-1:0] rx_count,
    output logic              full_flag,
    output logic              ovr_flag,
    output logic              rx_irq
);

    logic [CNT_W-1:0]  fifo_cnt;
    logic [DATA_W-1:0] head;
    logic              fifo_full;
    logic              accept;
    logic              overrun;
    logic              pop;
    logic [LVL_W-1:0]  cnt_after;
    logic [LVL_W-1:0]  trig_lvl;
    logic              full_set;
    logic [1:0]        trig_q;
    logic [DATA_W-1:0] rd_data_q;
    logic              irq_q;

    assign fifo_full = (fifo_cnt == CNT_W'(DEPTH));
    assign pop       = (data_rd || dma_rd) && (fifo_cnt != '0);
    assign cnt_after = {1'b0, fifo_cnt} + {{CNT_W{1'b0}}, accept}
                     - {{CNT_W{1'b0}}, pop};
    assign trig_lvl  = LVL_W'(trig_level(trig_q));
    assign full_set  = accept && (cnt_after >= trig_lvl);

    rx_accept_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (rx_enable),
        .byte_valid_i (byte_valid),
        .fifo_full_i  (fifo_full),
        .ovr_flag_i   (ovr_flag),
        .accept_o     (accept),
        .overrun_o    (overrun)
    );

    rx_byte_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (accept),
        .push_data_i (byte_data),
        .pop_i       (pop),
        .head_o      (head),
        .count_o     (fifo_cnt)
    );

    rx_sticky_flag u_full (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (full_set),
        .sw_rd_i   (stat_rd),
        .sw_wr_i   (stat_wr),
        .sw_wbit_i (stat_wr_full),
        .hw_clr_i  (dma_rd),
        .flag_o    (full_flag)
    );

    rx_sticky_flag u_ovr (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (overrun),
        .sw_rd_i   (stat_rd),
        .sw_wr_i   (stat_wr),
        .sw_wbit_i (stat_wr_ovr),
        .hw_clr_i  (1'b0),
        .flag_o    (ovr_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q    <= TRIG_1;
            rd_data_q <= '0;
            irq_q     <= 1'b0;
        end else begin
            if (cfg_trig_we) trig_q <= cfg_trig_code;
            if (pop) rd_data_q <= head;
            irq_q <= full_set && !full_flag;
        end
    end

    assign rd_data  = rd_data_q;
    assign rx_count = CNT_OUT_W'(fifo_cnt);
    assign rx_irq   = irq_q;

endmodule

// File: rtl/rx_fifo_status_ctrl_chk.sv
module rx_fifo_status_ctrl_chk #(
    parameter int DEPTH = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_enable,
    input logic       stat_wr,
    input logic       stat_wr_full,
    input logic       stat_wr_ovr,
    input logic       dma_rd,
    input logic [7:0] rx_count,
    input logic       full_flag,
    input logic       ovr_flag,
    input logic       rx_irq
);

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= 8'(DEPTH));

    p_irq_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (full_flag && !$past(full_flag)));

    p_full_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_flag) |-> $past(dma_rd || (stat_wr && !stat_wr_full)));

    p_ovr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_flag) |-> $past(stat_wr && !stat_wr_ovr));

    p_ovr_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_flag |=> (rx_count <= $past(rx_count)));

    p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> (rx_count <= $past(rx_count)));

endmodule

bind rx_fifo_status_ctrl rx_fifo_status_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_enable    (rx_enable),
    .stat_wr      (stat_wr),
    .stat_wr_full (stat_wr_full),
    .stat_wr_ovr  (stat_wr_ovr),
    .dma_rd       (dma_rd),
    .rx_count     (rx_count),
    .full_flag    (full_flag),
    .ovr_flag     (ovr_flag),
    .rx_irq       (rx_irq)
);

// File: tb/rx_fifo_status_ctrl_test.sv
`timescale 1ns/1ps
module rx_fifo_status_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_enable = 1'b0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       cfg_trig_we = 1'b0;
    logic [1:0] cfg_trig_code = '0;
    logic       stat_rd = 1'b0;
    logic       stat_wr = 1'b0;
    logic       stat_wr_full = 1'b1;
    logic       stat_wr_ovr = 1'b1;
    logic       data_rd = 1'b0;
    logic       dma_rd = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] rx_count;
    logic       full_flag;
    logic       ovr_flag;
    logic       rx_irq;

    always #2 clk = ~clk;

    rx_fifo_status_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .cfg_trig_we(cfg_trig_we), .cfg_trig_code(cfg_trig_code),
        .stat_rd(stat_rd), .stat_wr(stat_wr),
        .stat_wr_full(stat_wr_full), .stat_wr_ovr(stat_wr_ovr),
        .data_rd(data_rd), .dma_rd(dma_rd), .rd_data(rd_data),
        .rx_count(rx_count), .full_flag(full_flag), .ovr_flag(ovr_flag),
        .rx_irq(rx_irq)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // reference model state
    byte unsigned m_q[$];
    int  m_st = 0;          // 0 disabled, 1 taking bytes, 2 halted
    bit  m_full, m_ovr, m_armf, m_armo, m_irq;
    int  m_data = 0;
    int  m_trig = 1;

    function automatic int lvl_of(input int code);
        if (code == 0) return 1;
        if (code == 1) return 4;
        if (code == 2) return 8;
        return 14;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_st = 0; m_full = 0; m_ovr = 0; m_armf = 0; m_armo = 0;
            m_irq = 0; m_data = 0; m_trig = 1;
        end else begin
            int  cnt;
            bit  acc, ovf, popb, setf, clrf, clro, nf, no;
            int  nst;
            cnt  = m_q.size();
            acc  = (m_st == 1) && rx_enable && byte_valid && cnt < 16;
            ovf  = (m_st == 1) && rx_enable && byte_valid && cnt == 16;
            popb = (data_rd || dma_rd) && cnt > 0;
            if (popb) m_data = m_q.pop_front();
            if (acc) m_q.push_back(byte_data);
            setf = acc && (m_q.size() >= m_trig);
            clrf = dma_rd || (stat_wr && !stat_wr_full && m_armf);
            clro = stat_wr && !stat_wr_ovr && m_armo;
            nf   = setf ? 1'b1 : (clrf ? 1'b0 : m_full);
            no   = ovf ? 1'b1 : (clro ? 1'b0 : m_ovr);
            m_irq = setf && !m_full;
            if (dma_rd || stat_wr) m_armf = 0;
            else if (stat_rd && m_full) m_armf = 1;
            if (stat_wr) m_armo = 0;
            else if (stat_rd && m_ovr) m_armo = 1;
            nst = m_st;
            if (m_st == 0) nst = rx_enable ? 1 : 0;
            else if (m_st == 1) nst = !rx_enable ? 0 : (ovf ? 2 : 1);
            else if (!m_ovr) nst = rx_enable ? 1 : 0;
            m_st = nst;
            m_full = nf;
            m_ovr  = no;
            if (cfg_trig_we) m_trig = lvl_of(int'(cfg_trig_code));
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(rx_count == 8'(m_q.size()), "count", rx_count, m_q.size());
        check(full_flag == m_full, "full_flag", full_flag, m_full);
        check(ovr_flag == m_ovr, "ovr_flag", ovr_flag, m_ovr);
        check(rx_irq == m_irq, "rx_irq", rx_irq, m_irq);
        check(rd_data == 8'(m_data), "rd_data", rd_data, m_data);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        compare_all();
        byte_valid = 0; cfg_trig_we = 0; stat_rd = 0; stat_wr = 0;
        stat_wr_full = 1; stat_wr_ovr = 1; data_rd = 0; dma_rd = 0;
    endtask

    task automatic send(input logic [7:0] b);
        byte_valid = 1; byte_data = b; tick();
    endtask

    task automatic pop_sw();
        data_rd = 1; tick();
    endtask

    task automatic set_trig(input logic [1:0] c);
        cfg_trig_we = 1; cfg_trig_code = c; tick();
    endtask

    bit done = 0;

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cur_req = "R1";
        tick();
        check(rx_count == 0, "reset count", rx_count, 0);
        check(!full_flag && !ovr_flag && !rx_irq, "reset flags", full_flag, 0);
        check(rd_data == 0, "reset data", rd_data, 0);

        // R10: enable takes one cycle; byte in that cycle is dropped
        cur_req = "R10";
        rx_enable = 1; byte_valid = 1; byte_data = 8'hEE; tick();
        check(rx_count == 0, "byte during enable cycle", rx_count, 0);

        // R2 / R3 / R5: trigger level 1 by default
        cur_req = "R3";
        send(8'h11);
        check(full_flag == 1, "full at level 1", full_flag, 1);
        check(rx_irq == 1, "irq pulse R5", rx_irq, 1);
        cur_req = "R5";
        send(8'h22);
        check(rx_irq == 0, "irq single cycle", rx_irq, 0);
        cur_req = "R2";
        send(8'h33);
        pop_sw();
        check(rd_data == 8'h11, "first out", rd_data, 8'h11);
        pop_sw(); pop_sw();
        check(rd_data == 8'h33, "third out", rd_data, 8'h33);

        // R9: empty read
        cur_req = "R9";
        pop_sw();
        check(rd_data == 8'h33 && rx_count == 0, "empty read", rd_data, 8'h33);

        // R4: clear rules
        cur_req = "R4";
        stat_wr = 1; stat_wr_full = 0; tick();
        check(full_flag == 1, "write 0 without read", full_flag, 1);
        stat_rd = 1; tick();
        stat_wr = 1; stat_wr_full = 1; tick();
        check(full_flag == 1, "write 1", full_flag, 1);
        stat_wr = 1; stat_wr_full = 0; tick();
        check(full_flag == 1, "arm consumed", full_flag, 1);
        stat_rd = 1; tick();
        stat_wr = 1; stat_wr_full = 0; tick();
        check(full_flag == 0, "armed clear", full_flag, 0);

        // R3: level 4
        cur_req = "R3";
        set_trig(2'd1);
        send(8'h40); send(8'h41); send(8'h42);
        check(full_flag == 0, "below level 4", full_flag, 0);
        send(8'h43);
        check(full_flag == 1 && rx_irq == 1, "at level 4", full_flag, 1);

        // R11: re-set on next byte
        cur_req = "R11";
        stat_rd = 1; tick();
        stat_wr = 1; stat_wr_full = 0; tick();
        check(full_flag == 0, "cleared above level", full_flag, 0);
        tick();
        check(full_flag == 0, "no re-set without byte", full_flag, 0);
        send(8'h44);
        check(full_flag == 1 && rx_irq == 1, "re-set on byte", full_flag, 1);

        // R6: DMA read
        cur_req = "R6";
        dma_rd = 1; tick();
        check(full_flag == 0 && rx_count == 4, "dma clears", full_flag, 0);
        check(rd_data == 8'h40, "dma pops head", rd_data, 8'h40);
        for (int i = 0; i < 4; i++) begin dma_rd = 1; tick(); end

        // R3: levels 8 and 14
        cur_req = "R3";
        set_trig(2'd2);
        for (int i = 0; i < 7; i++) send(8'(8'h50 + i));
        check(full_flag == 0, "below level 8", full_flag, 0);
        send(8'h57);
        check(full_flag == 1, "at level 8", full_flag, 1);
        dma_rd = 1; tick();
        set_trig(2'd3);
        for (int i = 0; i < 6; i++) send(8'(8'h60 + i));
        check(full_flag == 0 && rx_count == 13, "below level 14", full_flag, 0);
        send(8'h66);
        check(full_flag == 1, "at level 14", full_flag, 1);
        send(8'h67); send(8'h68);
        check(rx_count == 16, "fifo full", rx_count, 16);

        // R7: overrun
        cur_req = "R7";
        send(8'hAA);
        check(ovr_flag == 1 && rx_count == 16, "overrun", ovr_flag, 1);

        // R8: halted
        cur_req = "R8";
        send(8'hAB); send(8'hAC);
        pop_sw();
        check(rd_data == 8'h51, "contents kept", rd_data, 8'h51);
        send(8'hAD);
        check(rx_count == 15, "halted", rx_count, 15);
        stat_wr = 1; stat_wr_ovr = 0; tick();
        check(ovr_flag == 1, "ovr write without read", ovr_flag, 1);
        stat_rd = 1; tick();
        stat_wr = 1; stat_wr_ovr = 0; tick();
        check(ovr_flag == 0, "ovr cleared", ovr_flag, 0);
        send(8'hAE);
        check(rx_count == 15, "exit cycle rejects", rx_count, 15);
        send(8'hAF);
        check(rx_count == 16, "accepting again", rx_count, 16);

        // R7: pop in same cycle as arrival at full
        cur_req = "R7";
        data_rd = 1; byte_valid = 1; byte_data = 8'hB0; tick();
        check(ovr_flag == 1 && rx_count == 15, "overrun with pop", rx_count, 15);
        stat_rd = 1; tick();
        stat_wr = 1; stat_wr_ovr = 0; tick();
        tick();

        // R10: disabled
        cur_req = "R10";
        rx_enable = 0; tick();
        send(8'hC0); send(8'hC1);
        check(rx_count == 15, "disabled ignores", rx_count, 15);

        cur_req = "R2";
        for (int i = 0; i < 16; i++) pop_sw();
        check(rx_count == 0, "drained", rx_count, 0);
        check(rd_data == 8'hAF, "last byte", rd_data, 8'hAF);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule